// File: doc/BRIEF.md
# Line-Scan Test Pattern Emulator

This block stands in for a row of four strip image sensors during bring-up, when no optics or real sensor silicon are present. It holds a one-bit test pattern of 704 by 704 pixels in read-only storage that is fixed when the device is configured. On a start request it plays the pattern out as a 2816 by 2816 eight-bit gray image. Each stored pixel becomes a run of four identical output pixels, and each stored row is sent as four identical output lines.

The pattern storage is built as two dual-port banks. Each bank holds one half of every stored row, so the two banks give four read ports between them. Each port serves one virtual sensor. In every clock cycle the four lanes of the output word carry one pixel for each sensor, and each sensor covers its own quarter of the widened line. Downstream logic receives a valid flag, a start-of-line and a start-of-frame marker with the first pixel, and a one-cycle completion pulse after the final line.

The content of the read-only storage is defined by a formula and is not held in a file. Byte b of stored row r holds (r + 3·b) mod 256, and stored pixel c is bit c mod 8 of byte c/8, with the least significant bit first.

Top module: `linescan_pattern_emu`

## Requirements
- R1: While reset is asserted, and in the first idle cycles after it, pix_valid_o, line_start_o, frame_start_o and frame_done_o are 0 and pix_o is all zero.
- R2: A start_i sampled high while idle begins a frame. The first output word appears on the second rising edge after the edge that sampled start_i, and it carries both frame_start_o and line_start_o. A rising pix_valid_o always coincides with frame_start_o.
- R3: A frame is OUT_H lines of SEG consecutive valid cycles, with SEG = PAT_W·REP/4, and has no idle cycle between lines. Lane s occupies pix_o bits [8s+7:8s] and in cycle t of a line carries widened pixel s·SEG + t.
- R4: Widened pixel x of a line shows stored column x / REP, so every stored pixel appears REP times in succession.
- R5: Output line L shows stored row L / LREP, so every stored row is sent LREP times. line_start_o marks the first word of every line, and frame_start_o only the first word of line 0.
- R6: A stored 1 is sent as gray 255 (8'hFF) and a stored 0 as gray 0. No other lane value appears while pix_valid_o is high.
- R7: Byte b of stored row r holds (r + 3·b) mod 256. Stored pixel c is bit (c mod 8) of byte c/8, with the least significant bit first.
- R8: frame_done_o is a one-cycle pulse in the cycle directly after the last word of the last line, with pix_valid_o low in that cycle. It appears at no other time.
- R9: start_i is ignored while a frame is being sent. The frame is not restarted and its word sequence is unchanged.
- R10: With start_i held high, the block returns to idle for one cycle after a frame. The next frame's first word follows two cycles after the previous frame's last word, and the done pulse falls in the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request, sampled while idle |
| pix_o | output | 32 | Four 8-bit gray pixels, lane s in bits [8s+7:8s] |
| pix_valid_o | output | 1 | pix_o carries a valid word |
| line_start_o | output | 1 | First word of an output line |
| frame_start_o | output | 1 | First word of a frame |
| frame_done_o | output | 1 | One-cycle pulse after the last word of a frame |

## Verification
A wrong value in one of the replication counters shifts the pixel or line pointer. Any such fault changes pix_o or a line marker within two cycles, once the pattern content differs at the new position. The formula gives different bytes for neighbouring rows and columns, so a row mix-up also shows within the first word of the affected line. A fault in the frame state machine appears either as a missing or extra word, which breaks the expected word count at the end of a frame, or as a misplaced done pulse, which shows in the cycle after the last word. An ignored-start fault shows as a second frame_start_o in the middle of the word stream.

// File: rtl/lsemu_pkg.sv
package lsemu_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int LANES    = 4;
  localparam int GRAY_W   = 8;
  localparam int BYTE_PIX = 8;

  // Fixed pattern content: byte b of row r is (r + 3*b) mod 256
  function automatic logic [7:0] pattern_byte(input logic [31:0] row,
                                              input logic [31:0] gbyte);
    logic [31:0] sum;
    sum = row + 32'd3 * gbyte;
    return sum[7:0];
  endfunction

endpackage

// File: rtl/lsemu_rom.sv
// One dual-port bank of the read-only pattern store (half of each row).
module lsemu_rom #(
  parameter int ROW_W     = 10,
  parameter int BYTE_W    = 6,
  parameter int BANK_BASE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic [1:0][ROW_W-1:0]  row_i,
  input  logic [1:0][BYTE_W-1:0] byte_i,
  output logic [1:0][7:0]        q_o
);
  logic [1:0][7:0] rd_d;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      rd_d[p] = lsemu_pkg::pattern_byte(32'(row_i[p]),
                                        32'(BANK_BASE) + 32'(byte_i[p]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (en_i) begin
      q_o <= rd_d;
    end
  end
endmodule

// File: rtl/lsemu_seq.sv
// Frame sequencer: pixel replication, column, line replication and row counters.
module lsemu_seq #(
  parameter int QPIX  = 176,
  parameter int REP   = 4,
  parameter int LREP  = 4,
  parameter int PAT_H = 704,
  parameter int PW    = $clog2(QPIX),
  parameter int RW    = (PAT_H > 1) ? $clog2(PAT_H) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          v0_o,
  output logic          sol0_o,
  output logic          sof0_o,
  output logic          last0_o,
  output logic [RW-1:0] row_o,
  output logic [PW-1:0] pix_o
);
  import lsemu_pkg::*;

  localparam int REP_W = (REP > 1) ? $clog2(REP) : 1;
  localparam int LW    = (LREP > 1) ? $clog2(LREP) : 1;

  seq_state_e       state_q, state_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [PW-1:0]    p_q, p_d;
  logic [LW-1:0]    lrep_q, lrep_d;
  logic [RW-1:0]    row_q, row_d;

  logic rep_wrap, p_wrap, lrep_wrap, row_wrap;

  assign rep_wrap  = (rep_q  == REP_W'(REP - 1));
  assign p_wrap    = (p_q    == PW'(QPIX - 1));
  assign lrep_wrap = (lrep_q == LW'(LREP - 1));
  assign row_wrap  = (row_q  == RW'(PAT_H - 1));

  always_comb begin
    state_d = state_q;
    rep_d   = rep_q;
    p_d     = p_q;
    lrep_d  = lrep_q;
    row_d   = row_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!rep_wrap) begin
          rep_d = rep_q + REP_W'(1);
        end else begin
          rep_d = '0;
          if (!p_wrap) begin
            p_d = p_q + PW'(1);
          end else begin
            p_d = '0;
            if (!lrep_wrap) begin
              lrep_d = lrep_q + LW'(1);
            end else begin
              lrep_d = '0;
              if (!row_wrap) begin
                row_d = row_q + RW'(1);
              end else begin
                row_d   = '0;
                state_d = ST_IDLE;
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rep_q   <= '0;
      p_q     <= '0;
      lrep_q  <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      rep_q   <= rep_d;
      p_q     <= p_d;
      lrep_q  <= lrep_d;
      row_q   <= row_d;
    end
  end

  assign v0_o    = (state_q == ST_RUN);
  assign sol0_o  = v0_o && (rep_q == '0) && (p_q == '0);
  assign sof0_o  = sol0_o && (lrep_q == '0) && (row_q == '0);
  assign last0_o = v0_o && rep_wrap && p_wrap && lrep_wrap && row_wrap;
  assign row_o   = row_q;
  assign pix_o   = p_q;

  // R9: a start seen mid-frame must not restart the frame
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (v0_o && !last0_o && start_i) |=> (v0_o && !sof0_o));

endmodule

// File: rtl/lsemu_pixout.sv
// Bit pick, gray expansion and output registers.
module lsemu_pixout #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  v_i,
  input  logic                  sol_i,
  input  logic                  sof_i,
  input  logic                  last_i,
  input  logic [2:0]            bit_i,
  input  logic [LANES-1:0][7:0] bytes_i,
  output logic [LANES-1:0][7:0] pix_o,
  output logic                  valid_o,
  output logic                  sol_o,
  output logic                  sof_o,
  output logic                  done_o
);
  logic [LANES-1:0][7:0] pix_d;
  logic                  last_q;

  always_comb begin
    for (int s = 0; s < LANES; s++) begin
      pix_d[s] = bytes_i[s][bit_i] ? 8'hFF : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
      sol_o   <= 1'b0;
      sof_o   <= 1'b0;
      last_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      pix_o   <= v_i ? pix_d : '0;
      valid_o <= v_i;
      sol_o   <= v_i && sol_i;
      sof_o   <= v_i && sof_i;
      last_q  <= v_i && last_i;
      done_o  <= valid_o && last_q;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R6: only full-scale black or white leaves the block
    assert_gray_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (pix_o[g] == 8'h00 || pix_o[g] == 8'hFF));
  end

endmodule

// File: rtl/linescan_pattern_emu.sv
module linescan_pattern_emu #(
  parameter int PAT_W = 704,
  parameter int PAT_H = 704,
  parameter int REP   = 4,
  parameter int LREP  = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      start_i,
  output logic [lsemu_pkg::LANES*lsemu_pkg::GRAY_W-1:0] pix_o,
  output logic                                      pix_valid_o,
  output logic                                      line_start_o,
  output logic                                      frame_start_o,
  output logic                                      frame_done_o
);
  import lsemu_pkg::*;

  localparam int QPIX       = PAT_W / LANES;
  localparam int QBYTES     = QPIX / BYTE_PIX;
  localparam int HALF_BYTES = 2 * QBYTES;
  localparam int PW         = $clog2(QPIX);
  localparam int RW         = (PAT_H > 1) ? $clog2(PAT_H) : 1;
  localparam int BYTE_W     = (HALF_BYTES > 1) ? $clog2(HALF_BYTES) : 1;

  logic          v0, sol0, sof0, last0;
  logic [RW-1:0] row0;
  logic [PW-1:0] p0;

  lsemu_seq #(
    .QPIX (QPIX),
    .REP  (REP),
    .LREP (LREP),
    .PAT_H(PAT_H),
    .PW   (PW),
    .RW   (RW)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .v0_o   (v0),
    .sol0_o (sol0),
    .sof0_o (sof0),
    .last0_o(last0),
    .row_o  (row0),
    .pix_o  (p0)
  );

  // Each of the four lanes reads its quarter; lanes 0,1 on bank 0, lanes 2,3 on bank 1
  logic [BYTE_W-1:0]     qbyte;
  logic [LANES-1:0][7:0] lane_byte;

  assign qbyte = BYTE_W'(p0 >> 3);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [1:0][RW-1:0]     row_a;
    logic [1:0][BYTE_W-1:0] byte_a;
    logic [1:0][7:0]        q;

    for (genvar p = 0; p < 2; p++) begin : g_port
      assign row_a[p]  = row0;
      assign byte_a[p] = BYTE_W'(p * QBYTES) + qbyte;
      assign lane_byte[2*b + p] = q[p];
    end

    lsemu_rom #(
      .ROW_W    (RW),
      .BYTE_W   (BYTE_W),
      .BANK_BASE(b * HALF_BYTES)
    ) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (v0),
      .row_i (row_a),
      .byte_i(byte_a),
      .q_o   (q)
    );
  end

  // Stage 1: control aligned with the bank read registers
  logic       v1, sol1, sof1, last1;
  logic [2:0] bit1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      sol1  <= 1'b0;
      sof1  <= 1'b0;
      last1 <= 1'b0;
      bit1  <= '0;
    end else begin
      v1    <= v0;
      sol1  <= sol0;
      sof1  <= sof0;
      last1 <= last0;
      if (v0) bit1 <= p0[2:0];
    end
  end

  logic [LANES-1:0][7:0] pix_lanes;

  lsemu_pixout #(.LANES(LANES)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .v_i    (v1),
    .sol_i  (sol1),
    .sof_i  (sof1),
    .last_i (last1),
    .bit_i  (bit1),
    .bytes_i(lane_byte),
    .pix_o  (pix_lanes),
    .valid_o(pix_valid_o),
    .sol_o  (line_start_o),
    .sof_o  (frame_start_o),
    .done_o (frame_done_o)
  );

  assign pix_o = pix_lanes;

  // R2: the stream only ever begins at a frame start
  assert_valid_rise_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid_o) |-> (frame_start_o && line_start_o));

  // R5: a frame start is always a valid line start
  assert_sof_on_sol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (line_start_o && pix_valid_o));

  // R8: done comes right after a valid word, in an idle cycle
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (!pix_valid_o && $past(pix_valid_o)));

endmodule

// File: tb/tb_linescan_pattern_emu.sv
module tb_linescan_pattern_emu;
  localparam int PW    = 64;
  localparam int PH    = 6;
  localparam int REP   = 4;
  localparam int LREP  = 4;
  localparam int SEG   = PW * REP / 4;
  localparam int OUT_H = PH * LREP;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] pix;
  logic        pvalid, lstart, fstart, fdone;

  always #4 clk = ~clk;

  linescan_pattern_emu #(.PAT_W(PW), .PAT_H(PH), .REP(REP), .LREP(LREP)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .pix_o        (pix),
    .pix_valid_o  (pvalid),
    .line_start_o (lstart),
    .frame_start_o(fstart),
    .frame_done_o (fdone)
  );

  typedef struct packed {
    logic [31:0] pix;
    logic        sol;
    logic        sof;
    logic        last;
  } exp_t;

  exp_t q[$];
  int   checks = 0, fails = 0;
  int   cyc = 0, last_cyc = 0, sof_cnt = 0, words = 0;
  bit   prev_last = 0, gap_check = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // R4 R5 R7: independent model of the widened pattern
  function automatic logic [7:0] exp_gray(input int line, input int x);
    int r, c, b;
    logic [7:0] byt;
    r   = line / LREP;
    c   = x / REP;
    b   = c / 8;
    byt = 8'((r + 3 * b) % 256);
    return byt[c % 8] ? 8'hFF : 8'h00;
  endfunction

  task automatic push_frame();
    for (int l = 0; l < OUT_H; l++) begin
      for (int t = 0; t < SEG; t++) begin
        exp_t e;
        for (int s = 0; s < 4; s++) e.pix[8*s +: 8] = exp_gray(l, s * SEG + t);
        e.sol  = (t == 0);
        e.sof  = (t == 0) && (l == 0);
        e.last = (l == OUT_H - 1) && (t == SEG - 1);
        q.push_back(e);
      end
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (fdone || prev_last)
        chk(fdone == prev_last, "R8", "frame_done timing", 32'(fdone), 32'(prev_last));
      prev_last = 0;
      if (pvalid) begin
        words++;
        if (q.size() == 0) begin
          chk(0, "R3", "unexpected valid word", pix, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(pix == e.pix, "R4 R7", "lane pixels", pix, e.pix);
          for (int s = 0; s < 4; s++)
            if (pix[8*s +: 8] != 8'h00 && pix[8*s +: 8] != 8'hFF)
              chk(0, "R6", "gray level", 32'(pix[8*s +: 8]), 32'hFF);
          chk(lstart == e.sol, "R5", "line_start", 32'(lstart), 32'(e.sol));
          chk(fstart == e.sof, "R2", "frame_start", 32'(fstart), 32'(e.sof));
          if (fstart && gap_check)
            chk(cyc - last_cyc == 2, "R10", "back-to-back gap", 32'(cyc - last_cyc), 32'd2);
          if (e.last) begin
            prev_last = 1;
            last_cyc  = cyc;
          end
        end
        if (fstart) sof_cnt++;
      end
    end
  end

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pvalid == 0 && fdone == 0, "R1", "valid/done in reset", {30'b0, pvalid, fdone}, 32'h0);
    chk(lstart == 0 && fstart == 0, "R1", "markers in reset", {30'b0, lstart, fstart}, 32'h0);
    chk(pix == 0, "R1", "pixels in reset", pix, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pvalid == 0 && pix == 0, "R1", "idle after reset", pix, 32'h0);

    // Frame A: single start pulse, latency check (R2)
    push_frame();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk(pvalid == 0, "R2", "no word one edge after start", 32'(pvalid), 32'd0);
    @(negedge clk);
    chk(pvalid == 1 && fstart == 1, "R2", "first word latency", {30'b0, pvalid, fstart}, 32'h3);
    wait_done();

    // Frame B: extra start mid-frame must be ignored (R9)
    push_frame();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (200) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done();
    chk(sof_cnt == 2, "R9", "frame starts after mid-frame start", 32'(sof_cnt), 32'd2);

    // Frames C and D: start held high (R9 R10)
    push_frame();
    push_frame();
    base  = sof_cnt;
    start = 1'b1;
    wait (sof_cnt == base + 1);
    gap_check = 1;
    wait (sof_cnt == base + 2);
    @(negedge clk);
    start     = 1'b0;
    gap_check = 0;
    wait_done();
    chk(sof_cnt == 4, "R9", "frame starts with held start", 32'(sof_cnt), 32'd4);
    // R3: total word count over four frames
    chk(words == 4 * OUT_H * SEG, "R3", "total words", 32'(words), 32'(4 * OUT_H * SEG));
    repeat (20) @(negedge clk);
    chk(pvalid == 0 && q.size() == 0, "R3", "idle after frames", 32'(pvalid), 32'd0);
    summary();
  end
endmodule